// File: doc/BRIEF.md
# Clocked and Unclocked Chip Select Decoder

This block turns the current 16-bit bus address into eight active-low chip select strobes that share one 8-bit output port. Each strobe belongs to one fixed window of external memory. A strobe reaches its pin only when that pin has been switched into select mode. Otherwise the pin carries the ordinary port data bit. Select mode comes from a per-pin enable byte. Pin 7 is also put into select mode by bit 7 of the bus control byte.

The selects fall into two timing classes. Selects 3 to 7 are gated by the PHI2 clock phase and can go low only while PHI2 is high. Selects 0 to 2 follow the address alone and stay low for as long as the address sits in their window, whatever the phase. When the access targets on-chip memory, which the bus-active input shows as low, every select stays high. The block is purely combinational from its inputs to its pins.

Top module: `chip_select_decoder`

## Requirements
- R1: A pin in select mode is driven 0 (asserted) exactly when busActive is 1, the address lies inside that pin's window, and the phase rule of R5/R6 allows it. Otherwise it is driven 1.
- R2: Default windows, inclusive: select 0 = 0x0100–0x01FF, 1 = 0x0200–0x03FF, 2 = 0x0400–0x07FF, 3 = 0x0800–0x0FFF, 4 = 0x1000–0x1FFF, 5 = 0x2000–0x3FFF, 6 = 0x4000–0x7FFF, 7 = 0x8000–0xFFFF. Addresses 0x0000–0x00FF belong to no select.
- R3: Bit i of selEnable puts pin i into select mode.
- R4: busCtrl bit 7 = 1 puts pin 7 into select mode even when selEnable bit 7 is 0. The other busCtrl bits have no effect on any pin.
- R5: Selects 3 to 7 can assert only while phi2 is 1.
- R6: Selects 0 to 2 assert with phi2 at 0 or at 1.
- R7: A pin not in select mode drives portData bit i.
- R8: With busActive = 0 (on-chip access), no pin in select mode is driven 0.
- R9: At most one pin in select mode is driven 0 at any time.
- R10: pinIsSelect bit i is 1 exactly when pin i is in select mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Current bus address |
| phi2 | input | 1 | Bus clock phase, 1 = high phase |
| busActive | input | 1 | 1 = the access goes to external memory, 0 = on-chip |
| selEnable | input | 8 | Per-pin chip select enable byte |
| busCtrl | input | 8 | Bus control byte; only bit 7 is used |
| portData | input | 8 | Ordinary port output data |
| pinOut | output | 8 | Port pin levels, active-low selects in select mode |
| pinIsSelect | output | 8 | 1 where the pin is currently in select mode |

## Verification
The hardest situation to reach is the overlap of pin 7's two mode sources with the phase gate. The forced select must assert on a high phase, release on a low phase, and stay in select mode when its enable bit is cleared. The bench gets there by holding selEnable bit 7 at 0 and toggling busCtrl bit 7 and phi2 around an address in the top window. Window edges are probed on both sides of every boundary, in both phases, so that a clocked select and its unclocked neighbour are told apart.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int NUM_SEL = 8;
  localparam int ADDR_W  = 16;

  typedef struct packed {
    logic [NUM_SEL-1:0] selMode;  // pin is in chip select mode
    logic [NUM_SEL-1:0] phaseOk;  // timing class and bus state allow assertion
  } csStrobes_t;

  localparam logic [NUM_SEL*ADDR_W-1:0] DEF_LO = {
    16'h8000, 16'h4000, 16'h2000, 16'h1000,
    16'h0800, 16'h0400, 16'h0200, 16'h0100
  };
  localparam logic [NUM_SEL*ADDR_W-1:0] DEF_HI = {
    16'hFFFF, 16'h7FFF, 16'h3FFF, 16'h1FFF,
    16'h0FFF, 16'h07FF, 16'h03FF, 16'h01FF
  };
  localparam logic [NUM_SEL-1:0] DEF_CLOCKED = 8'hF8;
endpackage

// File: rtl/csdec_window_match.sv
module csdec_window_match
  import csdec_pkg::*;
#(
  parameter logic [NUM_SEL*ADDR_W-1:0] BLOCK_LO = DEF_LO,
  parameter logic [NUM_SEL*ADDR_W-1:0] BLOCK_HI = DEF_HI
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_SEL-1:0] inBlock
);
  for (genvar g = 0; g < NUM_SEL; g++) begin : gWin
    localparam logic [ADDR_W-1:0] LO = BLOCK_LO[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI = BLOCK_HI[g*ADDR_W +: ADDR_W];
    assign inBlock[g] = (addr >= LO) && (addr <= HI);
  end

  // windows must not overlap
  always_comb begin
    p_single_block_r9: assert ($onehot0(inBlock))
      else $error("address hits more than one window");
  end
endmodule

// File: rtl/csdec_select_ctrl.sv
module csdec_select_ctrl
  import csdec_pkg::*;
#(
  parameter logic [NUM_SEL-1:0] CLOCKED_MASK = DEF_CLOCKED,
  parameter int                 FORCE_IDX    = 7,
  parameter int                 FORCE_BIT    = 7
) (
  input  logic               phi2,
  input  logic               busActive,
  input  logic [NUM_SEL-1:0] selEnable,
  input  logic [7:0]         busCtrl,
  output csStrobes_t         strobes
);
  for (genvar g = 0; g < NUM_SEL; g++) begin : gCtl
    if (g == FORCE_IDX) begin : gForced
      assign strobes.selMode[g] = selEnable[g] | busCtrl[FORCE_BIT];
    end else begin : gPlain
      assign strobes.selMode[g] = selEnable[g];
    end
    if (CLOCKED_MASK[g]) begin : gClocked
      assign strobes.phaseOk[g] = busActive & phi2;
    end else begin : gFree
      assign strobes.phaseOk[g] = busActive;
    end
  end

  always_comb begin
    p_onchip_blocks_r8: assert (busActive || strobes.phaseOk == '0)
      else $error("phase permit raised for on-chip access");
  end
endmodule

// File: rtl/csdec_pin_datapath.sv
module csdec_pin_datapath
  import csdec_pkg::*;
(
  input  csStrobes_t         strobes,
  input  logic [NUM_SEL-1:0] inBlock,
  input  logic [NUM_SEL-1:0] portData,
  output logic [NUM_SEL-1:0] pinOut,
  output logic [NUM_SEL-1:0] pinIsSelect
);
  logic [NUM_SEL-1:0] selAsserted;

  for (genvar g = 0; g < NUM_SEL; g++) begin : gPin
    assign selAsserted[g] = strobes.selMode[g] & strobes.phaseOk[g] & inBlock[g];
    assign pinOut[g]      = strobes.selMode[g] ? ~selAsserted[g] : portData[g];
  end
  assign pinIsSelect = strobes.selMode;

  always_comb begin
    p_one_low_r9: assert ($onehot0(~pinOut & pinIsSelect))
      else $error("more than one select low");
  end
endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
  import csdec_pkg::*;
#(
  parameter logic [NUM_SEL*ADDR_W-1:0] BLOCK_LO     = DEF_LO,
  parameter logic [NUM_SEL*ADDR_W-1:0] BLOCK_HI     = DEF_HI,
  parameter logic [NUM_SEL-1:0]        CLOCKED_MASK = DEF_CLOCKED,
  parameter int                        FORCE_IDX    = 7,
  parameter int                        FORCE_BIT    = 7
) (
  input  logic [15:0] addr,
  input  logic        phi2,
  input  logic        busActive,
  input  logic [7:0]  selEnable,
  input  logic [7:0]  busCtrl,
  input  logic [7:0]  portData,
  output logic [7:0]  pinOut,
  output logic [7:0]  pinIsSelect
);
  logic [NUM_SEL-1:0] inBlock;
  csStrobes_t         strobes;

  csdec_window_match #(.BLOCK_LO(BLOCK_LO), .BLOCK_HI(BLOCK_HI)) uWin (
    .addr(addr), .inBlock(inBlock)
  );

  csdec_select_ctrl #(
    .CLOCKED_MASK(CLOCKED_MASK), .FORCE_IDX(FORCE_IDX), .FORCE_BIT(FORCE_BIT)
  ) uCtl (
    .phi2(phi2), .busActive(busActive), .selEnable(selEnable),
    .busCtrl(busCtrl), .strobes(strobes)
  );

  csdec_pin_datapath uDp (
    .strobes(strobes), .inBlock(inBlock), .portData(portData),
    .pinOut(pinOut), .pinIsSelect(pinIsSelect)
  );

  always_comb begin
    p_clocked_phase_r5: assert (phi2 || ((~pinOut & pinIsSelect & CLOCKED_MASK) == '0))
      else $error("clocked select low in low phase");
    p_offchip_quiet_r8: assert (busActive || ((~pinOut & pinIsSelect) == '0))
      else $error("select low during on-chip access");
    p_forced_mode_r4: assert (!busCtrl[FORCE_BIT] || pinIsSelect[FORCE_IDX])
      else $error("forced select not in select mode");
    p_port_pass_r7: assert (((pinOut ^ portData) & ~pinIsSelect) == '0)
      else $error("non-select pin differs from port data");
  end
endmodule

// File: tb/test_chip_select_decoder.sv
`timescale 1ns/1ps
module test_chip_select_decoder;
  logic        clk = 1'b0;
  logic [15:0] addr = '0;
  logic        phi2 = 1'b0;
  logic        busActive = 1'b0;
  logic [7:0]  selEnable = '0;
  logic [7:0]  busCtrl = '0;
  logic [7:0]  portData = '0;
  logic [7:0]  pinOut, pinIsSelect;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chip_select_decoder i_chip_select_decoder (
    .addr(addr), .phi2(phi2), .busActive(busActive), .selEnable(selEnable),
    .busCtrl(busCtrl), .portData(portData), .pinOut(pinOut), .pinIsSelect(pinIsSelect)
  );

  // window index from the R2 table: highest set bit among 8..15
  function automatic int blockOf(input logic [15:0] a);
    int r = -1;
    for (int b = 8; b < 16; b++) if (a[b]) r = b - 8;
    return r;
  endfunction

  function automatic logic [7:0] expMode(input logic [7:0] en, input logic [7:0] bc);
    logic [7:0] m = en;
    m[7] = en[7] | bc[7];
    return m;
  endfunction

  function automatic logic [7:0] expPins();
    logic [7:0] m = expMode(selEnable, busCtrl);
    logic [7:0] p;
    int blk = blockOf(addr);
    for (int i = 0; i < 8; i++) begin
      logic act = m[i] && busActive && (blk == i) && (i < 3 || phi2);
      p[i] = m[i] ? ~act : portData[i];
    end
    return p;
  endfunction

  task automatic apply(input logic [15:0] a, input logic ph, input logic ba,
                       input logic [7:0] en, input logic [7:0] bc, input logic [7:0] pd);
    @(posedge clk);
    addr = a; phi2 = ph; busActive = ba; selEnable = en; busCtrl = bc; portData = pd;
    @(negedge clk);
  endtask

  task automatic check(input string tag);
    logic [7:0] ep = expPins();
    logic [7:0] em = expMode(selEnable, busCtrl);
    total++;
    if (pinOut !== ep || pinIsSelect !== em) begin
      bad++;
      $display("FAIL %s addr=%h phi2=%b: pins=%b mode=%b expected pins=%b mode=%b",
               tag, addr, phi2, pinOut, pinIsSelect, ep, em);
    end
  endtask

  task automatic t_idle();  // R7 R10 idle state
    apply(16'h0000, 0, 0, 8'h00, 8'h00, 8'h00); check("R7 idle zero");
    apply(16'h9000, 1, 1, 8'h00, 8'h00, 8'hA5); check("R7 port pass");
  endtask

  task automatic t_unclocked();  // R6 R1
    apply(16'h0150, 1, 1, 8'hFF, 8'h00, 8'h00); check("R6 sel0 phi2 high");
    apply(16'h0150, 0, 1, 8'hFF, 8'h00, 8'h00); check("R6 sel0 phi2 low");
    apply(16'h0300, 0, 1, 8'hFF, 8'h00, 8'h00); check("R6 sel1 phi2 low");
    apply(16'h0600, 0, 1, 8'hFF, 8'h00, 8'h00); check("R6 sel2 phi2 low");
  endtask

  task automatic t_clocked();  // R5 R1
    apply(16'h0900, 1, 1, 8'hFF, 8'h00, 8'h00); check("R5 sel3 high");
    apply(16'h0900, 0, 1, 8'hFF, 8'h00, 8'h00); check("R5 sel3 low");
    apply(16'h5000, 0, 1, 8'hFF, 8'h00, 8'h00); check("R5 sel6 low");
    apply(16'hC000, 1, 1, 8'hFF, 8'h00, 8'h00); check("R5 sel7 high");
  endtask

  task automatic t_enable();  // R3 R7 R10
    apply(16'h1800, 1, 1, 8'hEF, 8'h00, 8'h10); check("R3 sel4 disabled");
    apply(16'h1800, 1, 1, 8'h10, 8'h00, 8'h00); check("R3 sel4 only enabled");
    apply(16'h0250, 1, 1, 8'h05, 8'h00, 8'hFA); check("R10 mixed modes");
  endtask

  task automatic t_force();  // R4
    apply(16'hF000, 1, 1, 8'h00, 8'h80, 8'h00); check("R4 forced sel7 asserts");
    apply(16'hF000, 0, 1, 8'h00, 8'h80, 8'h00); check("R4 forced sel7 phase low");
    apply(16'hF000, 1, 1, 8'h00, 8'h7F, 8'hFF); check("R4 other ctrl bits no effect");
    apply(16'h0100, 1, 1, 8'h00, 8'h7F, 8'h00); check("R4 ctrl bits no effect sel0");
  endtask

  task automatic t_onchip();  // R8
    apply(16'h0150, 1, 0, 8'hFF, 8'h80, 8'h00); check("R8 onchip sel0");
    apply(16'hF000, 1, 0, 8'hFF, 8'h80, 8'h00); check("R8 onchip sel7");
  endtask

  task automatic t_bounds();  // R2 R9
    logic [15:0] edges [16] = '{16'h00FF, 16'h0100, 16'h01FF, 16'h0200, 16'h03FF, 16'h0400,
                                16'h07FF, 16'h0800, 16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000,
                                16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000};
    for (int k = 0; k < 16; k++)
      for (int ph = 0; ph < 2; ph++) begin
        apply(edges[k], ph[0], 1, 8'hFF, 8'h00, 8'h00);
        check("R2 window edge");
        total++;
        if ($countones(~pinOut) > 1) begin
          bad++;
          $display("FAIL R9 addr=%h lows=%0d expected <=1", addr, $countones(~pinOut));
        end
      end
    apply(16'hFFFF, 1, 1, 8'hFF, 8'h00, 8'h00); check("R2 top address");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_unclocked();
    t_clocked();
    t_enable();
    t_force();
    t_onchip();
    t_bounds();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule